// File: doc/BRIEF.md
# Memory-Bus Link Protocol Monitor

This block sits passively beside one master-to-slave link of a simple synchronous memory-style bus. The link carries a chip select, a write enable, per-byte lane selects, an address, write data, an acknowledge and an error response. A request is held by the master until the slave acknowledges it, and the acknowledge may arrive in the same cycle as the request. The monitor drives nothing on the bus. It watches every cycle and raises a sticky violation flag the first time a handshake, stability, error or reset rule is broken. Alongside the flag it holds a code that names that first rule.

The monitor also keeps three saturating counters: completed reads, completed writes and error responses. A verification environment or a debug observer can read these and the violation code at any time. Read data is not examined.

Top module: `membus_link_monitor`

## Requirements
- R1: While `rst_n` is low, all bus inputs are ignored. At the first clock edge with `rst_n` low, `viol_flag`, `viol_code` and all three counters become 0.
- R2: In the first clock cycle after `rst_n` goes high, `cs` must be 0. A high `cs` in that cycle is rule code 1.
- R3: `ack` high while `cs` is low is rule code 2.
- R4: `err` high in a cycle without `ack` high is rule code 3.
- R5: Once a transfer is pending (`cs` high with no `ack` in an earlier cycle, and no `ack` since), `cs` low is rule code 4.
- R6: While a transfer is pending, any change of `we`, `sel`, `adr` or `dat_w` from the values seen in its first cycle is rule code 5. This includes `sel` changes during a read. In the cycle after an `ack`, new values are legal.
- R7: If several rules break in the same cycle, the lowest code is recorded.
- R8: The first violation sets `viol_flag` and latches its nonzero code. Both hold unchanged until reset, whatever later violations occur.
- R9: A cycle with `cs`, `ack` and `we` high adds one to `wr_count`, even when `sel` is all zero. A cycle with `cs` and `ack` high and `we` low adds one to `rd_count`.
- R10: A cycle with `cs`, `ack` and `err` all high adds one to `err_count`.
- R11: Each counter saturates at all ones (2^CNT_W-1) and does not wrap.
- R12: All outputs are registered. The effect of a bus cycle shows on the outputs after the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Master chip select, request valid |
| we | input | 1 | 1 = write, 0 = read |
| sel | input | SEL_W | Byte lane selects |
| adr | input | ADR_W | Request address |
| dat_w | input | DAT_W | Write data |
| ack | input | 1 | Slave acknowledge |
| err | input | 1 | Slave error response |
| viol_flag | output | 1 | Sticky violation indicator |
| viol_code | output | 3 | Code of the first broken rule (0 = none) |
| rd_count | output | CNT_W | Completed reads, saturating |
| wr_count | output | CNT_W | Completed writes, saturating |
| err_count | output | CNT_W | Error responses, saturating |

## Verification
A wrong pending bit or a stale request snapshot shows up at the ports in one of two ways. Legal back-to-back traffic may raise code 4 or 5 one clock after the cycle that follows an acknowledge. Or a real stall violation may leave `viol_flag` low. A bad priority or a lost sticky latch shows as a wrong or changed `viol_code` one clock after the colliding cycle. Counter faults show as a mismatch on the edge after the completing cycle, or as a wrap after saturation. The reference model is compared against the outputs every cycle, so any of these is reported at the first clock where it appears.

// File: rtl/membus_mon_pkg.sv
// Package: shared rule codes and counter indices for the link monitor.
// Assumes: codes are ordered by priority, lowest value wins.
package membus_mon_pkg;

    localparam int unsigned CODE_W     = 3;
    localparam int unsigned RULE_COUNT = 5;

    typedef enum logic [CODE_W-1:0] {
        VC_NONE       = 3'd0,
        VC_FIRST_BUSY = 3'd1,
        VC_ACK_IDLE   = 3'd2,
        VC_ERR_NO_ACK = 3'd3,
        VC_CS_DROP    = 3'd4,
        VC_REQ_MOVED  = 3'd5
    } rule_code_e;

    localparam int unsigned CNT_KINDS = 3;
    localparam int unsigned CNT_RD    = 0;
    localparam int unsigned CNT_WR    = 1;
    localparam int unsigned CNT_ERR   = 2;

endpackage

// File: rtl/mbm_txn_tracker.sv
// Module: mbm_txn_tracker
// Tracks whether a request is pending, keeps a snapshot of the request
// fields taken in its first cycle, and flags the first cycle after reset.
// Assumes: a request completes in any cycle where cs and ack are both high.
module mbm_txn_tracker #(
    parameter int unsigned SEL_W = 4,
    parameter int unsigned ADR_W = 16,
    parameter int unsigned DAT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [ADR_W-1:0] adr,
    input  logic [DAT_W-1:0] dat_w,
    input  logic             ack,
    output logic             pend,
    output logic             first_cyc,
    output logic             req_moved
);
    localparam int unsigned REQ_W = 1 + SEL_W + ADR_W + DAT_W;

    logic [REQ_W-1:0] req_now;
    logic [REQ_W-1:0] snap_q;
    logic             pend_q;
    logic             first_q;

    // Pack the request fields into one compare vector.
    assign req_now = {we, sel, adr, dat_w};

    // Pending state, snapshot capture and first-cycle marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            first_q <= 1'b1;
            snap_q  <= '0;
        end else begin
            first_q <= 1'b0;
            if (!pend_q) begin
                if (cs && !ack) begin
                    pend_q <= 1'b1;
                    snap_q <= req_now;
                end
            end else if (!cs || ack) begin
                pend_q <= 1'b0;
            end
        end
    end

    // A pending request whose fields differ from the snapshot has moved.
    assign req_moved = pend_q && cs && (req_now != snap_q);
    assign pend      = pend_q;
    assign first_cyc = first_q;

    // R6: a stalled request must be remembered as pending in the next cycle.
    assert_stall_tracked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !ack) |=> pend);

    // R2: the first-cycle marker lasts exactly one cycle out of reset.
    assert_first_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        first_cyc |=> !first_cyc);

endmodule

// File: rtl/mbm_rule_eval.sv
// Module: mbm_rule_eval
// Evaluates each rule every cycle, picks the lowest-numbered broken rule,
// and latches it once into a sticky flag and code.
// Assumes: tracker inputs describe the state before the current cycle.
module mbm_rule_eval
    import membus_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       first_cyc,
    input  logic       pend,
    input  logic       req_moved,
    input  logic       cs,
    input  logic       ack,
    input  logic       err,
    output logic       flag_q,
    output rule_code_e code_q
);
    logic [RULE_COUNT:1] hits;
    rule_code_e          first_hit;

    // Raw rule checks for the current cycle, one bit per code.
    always_comb begin
        hits    = '0;
        hits[1] = first_cyc && cs;
        hits[2] = ack && !cs;
        hits[3] = err && !ack;
        hits[4] = pend && !cs;
        hits[5] = req_moved;
    end

    // Priority pick: scan downward so the lowest set code wins.
    always_comb begin
        first_hit = VC_NONE;
        for (int i = RULE_COUNT; i >= 1; i--) begin
            if (hits[i]) first_hit = rule_code_e'(3'(i));
        end
    end

    // Sticky capture of the first violation until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            code_q <= VC_NONE;
        end else if (!flag_q && (first_hit != VC_NONE)) begin
            flag_q <= 1'b1;
            code_q <= first_hit;
        end
    end

    // R8: once raised, the flag and code never move until reset.
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> (flag_q && $stable(code_q)));

    // R8: a raised flag always carries a real rule code.
    assert_code_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |-> (code_q != VC_NONE));

endmodule

// File: rtl/mbm_sat_counter.sv
// Module: mbm_sat_counter
// Event counter that stops at all ones instead of wrapping.
// Assumes: inc is a single-cycle event strobe.
module mbm_sat_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] count_q;

    // Count events, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (inc && (count_q != MAXV)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

    // R11: a full counter stays full when another event arrives.
    assert_sat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count == MAXV) |=> (count == MAXV));

    // R9: below the limit each event steps the count by exactly one.
    assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count != MAXV) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/membus_link_monitor.sv
// Module: membus_link_monitor (top)
// Passive protocol monitor for one link of the memory-style bus. It raises a
// sticky violation with a rule code and counts reads, writes and errors.
// Assumes: all inputs are synchronous to clk; drives nothing on the bus.
module membus_link_monitor
    import membus_mon_pkg::*;
#(
    parameter int unsigned SEL_W = 4,
    parameter int unsigned ADR_W = 16,
    parameter int unsigned DAT_W = 32,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [ADR_W-1:0] adr,
    input  logic [DAT_W-1:0] dat_w,
    input  logic             ack,
    input  logic             err,
    output logic             viol_flag,
    output logic [2:0]       viol_code,
    output logic [CNT_W-1:0] rd_count,
    output logic [CNT_W-1:0] wr_count,
    output logic [CNT_W-1:0] err_count
);
    logic                 pend;
    logic                 first_cyc;
    logic                 req_moved;
    rule_code_e           code;
    logic                 done;
    logic [CNT_KINDS-1:0] inc_vec;
    logic [CNT_W-1:0]     cnt [CNT_KINDS];

    mbm_txn_tracker #(
        .SEL_W (SEL_W),
        .ADR_W (ADR_W),
        .DAT_W (DAT_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .we        (we),
        .sel       (sel),
        .adr       (adr),
        .dat_w     (dat_w),
        .ack       (ack),
        .pend      (pend),
        .first_cyc (first_cyc),
        .req_moved (req_moved)
    );

    mbm_rule_eval u_rules (
        .clk       (clk),
        .rst_n     (rst_n),
        .first_cyc (first_cyc),
        .pend      (pend),
        .req_moved (req_moved),
        .cs        (cs),
        .ack       (ack),
        .err       (err),
        .flag_q    (viol_flag),
        .code_q    (code)
    );

    // Completion events that drive the three counters.
    assign done             = cs && ack;
    assign inc_vec[CNT_RD]  = done && !we;
    assign inc_vec[CNT_WR]  = done && we;
    assign inc_vec[CNT_ERR] = done && err;

    for (genvar g = 0; g < CNT_KINDS; g++) begin : g_cnt
        mbm_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[g]),
            .count (cnt[g])
        );
    end

    assign viol_code = code;
    assign rd_count  = cnt[CNT_RD];
    assign wr_count  = cnt[CNT_WR];
    assign err_count = cnt[CNT_ERR];

    // R3: an acknowledge with no request leaves the flag raised next cycle.
    assert_ack_idle_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !cs) |=> viol_flag);

    // R4: an error without acknowledge leaves the flag raised next cycle.
    assert_err_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !ack) |=> viol_flag);

    // R5: dropping a pending request raises code 4 if nothing came first.
    assert_cs_drop_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol_flag && pend && !cs && !ack && !err) |=> (viol_flag && viol_code == 3'd4));

    // R12: counters only move after a completing cycle.
    assert_rd_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && ack && !we) |=> $stable(rd_count));

endmodule

// File: tb/membus_link_monitor_test.sv
module membus_link_monitor_test;
    localparam int SEL_W = 4;
    localparam int ADR_W = 8;
    localparam int DAT_W = 16;
    localparam int CNT_W = 4;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs = 1'b0, we = 1'b0, ack = 1'b0, err = 1'b0;
    logic [SEL_W-1:0] sel = '0;
    logic [ADR_W-1:0] adr = '0;
    logic [DAT_W-1:0] dat_w = '0;
    logic             viol_flag;
    logic [2:0]       viol_code;
    logic [CNT_W-1:0] rd_count, wr_count, err_count;

    int checks = 0;
    int errors = 0;
    bit started = 0;

    // Reference model state
    int m_flag, m_code, m_rd, m_wr, m_er, m_pend, m_first;
    logic             s_we;
    logic [SEL_W-1:0] s_sel;
    logic [ADR_W-1:0] s_adr;
    logic [DAT_W-1:0] s_dat;

    membus_link_monitor #(.SEL_W(SEL_W), .ADR_W(ADR_W), .DAT_W(DAT_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .sel(sel), .adr(adr),
        .dat_w(dat_w), .ack(ack), .err(err), .viol_flag(viol_flag),
        .viol_code(viol_code), .rd_count(rd_count), .wr_count(wr_count),
        .err_count(err_count)
    );

    always #4 clk = ~clk;

    // Behavioural model of the rules, advanced on each rising edge.
    always @(posedge clk) begin
        int hit;
        started = 1;
        if (!rst_n) begin
            m_flag = 0; m_code = 0; m_rd = 0; m_wr = 0; m_er = 0;
            m_pend = 0; m_first = 1;
        end else begin
            hit = 0;
            if (m_first == 1 && cs) hit = 1;
            else if (ack && !cs) hit = 2;
            else if (err && !ack) hit = 3;
            else if (m_pend == 1 && !cs) hit = 4;
            else if (m_pend == 1 && (we !== s_we || sel !== s_sel || adr !== s_adr || dat_w !== s_dat)) hit = 5;
            if (m_flag == 0 && hit != 0) begin m_flag = 1; m_code = hit; end
            if (cs && ack) begin
                if (we) begin if (m_wr < MAXC) m_wr++; end
                else    begin if (m_rd < MAXC) m_rd++; end
                if (err && m_er < MAXC) m_er++;
            end
            if (m_pend == 0) begin
                if (cs && !ack) begin
                    m_pend = 1; s_we = we; s_sel = sel; s_adr = adr; s_dat = dat_w;
                end
            end else if (!cs || ack) m_pend = 0;
            m_first = 0;
        end
    end

    // R12: per-cycle comparison of all outputs against the model.
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (viol_flag !== (m_flag != 0) || viol_code !== 3'(m_code) ||
                rd_count !== CNT_W'(m_rd) || wr_count !== CNT_W'(m_wr) || err_count !== CNT_W'(m_er)) begin
                errors++;
                $display("FAIL R12 model t=%0t actual flag=%0d code=%0d rd=%0d wr=%0d er=%0d expected flag=%0d code=%0d rd=%0d wr=%0d er=%0d",
                         $time, viol_flag, viol_code, rd_count, wr_count, err_count,
                         m_flag, m_code, m_rd, m_wr, m_er);
            end
        end
    end

    task automatic drive(input logic c, input logic w, input logic [SEL_W-1:0] s,
                         input logic [ADR_W-1:0] a, input logic [DAT_W-1:0] d,
                         input logic k, input logic e);
        @(negedge clk);
        cs = c; we = w; sel = s; adr = a; dat_w = d; ack = k; err = e;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b0);
    endtask

    task automatic do_reset(input logic cs_at_release);
        @(negedge clk);
        rst_n = 1'b0;
        cs = 1'b1; ack = 1'b1; err = 1'b1; we = 1'b1;
        repeat (2) @(negedge clk);
        cs = cs_at_release; we = 1'b0; ack = cs_at_release; err = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic expect_state(input int flag, input int code, input int rd,
                                input int wr, input int er, input string tag);
        idle();
        @(negedge clk);
        #1;
        checks++;
        if (viol_flag !== (flag != 0) || viol_code !== 3'(code) || rd_count !== CNT_W'(rd) ||
            wr_count !== CNT_W'(wr) || err_count !== CNT_W'(er)) begin
            errors++;
            $display("FAIL %s actual flag=%0d code=%0d rd=%0d wr=%0d er=%0d expected flag=%0d code=%0d rd=%0d wr=%0d er=%0d",
                     tag, viol_flag, viol_code, rd_count, wr_count, err_count, flag, code, rd, wr, er);
        end
    endtask

    initial begin
        // R1: garbage on the bus while reset is held must leave everything zero.
        rst_n = 1'b0; cs = 1'b1; ack = 1'b1; err = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (viol_flag !== 1'b0 || viol_code !== 3'd0 || rd_count !== '0 || wr_count !== '0 || err_count !== '0) begin
            errors++;
            $display("FAIL R1 actual flag=%0d code=%0d rd=%0d expected 0 0 0", viol_flag, viol_code, rd_count);
        end
        do_reset(1'b0);

        // R9 R10 R6: clean mixed traffic, stalls and back-to-back changes after ack.
        drive(1, 1, 4'hF, 8'h10, 16'h1111, 1, 0);
        drive(1, 1, 4'h3, 8'h14, 16'h2222, 0, 0);
        drive(1, 1, 4'h3, 8'h14, 16'h2222, 0, 0);
        drive(1, 1, 4'h3, 8'h14, 16'h2222, 1, 0);
        drive(1, 0, 4'h4, 8'h20, 16'h0000, 1, 0);
        drive(1, 0, 4'h1, 8'h24, 16'h0000, 0, 0);
        drive(1, 0, 4'h1, 8'h24, 16'h0000, 1, 1);
        drive(1, 1, 4'h0, 8'h30, 16'h3333, 1, 0);
        expect_state(0, 0, 2, 3, 1, "R9 R10 R6 clean traffic");

        // R2: request present in the first cycle out of reset.
        do_reset(1'b1);
        expect_state(1, 1, 1, 0, 0, "R2 first cycle busy");

        // R3: acknowledge while idle.
        do_reset(1'b0);
        drive(0, 0, 4'h0, 8'h00, 16'h0000, 1, 0);
        expect_state(1, 2, 0, 0, 0, "R3 ack without cs");

        // R4: error without acknowledge.
        do_reset(1'b0);
        idle();
        drive(1, 0, 4'hF, 8'h40, 16'h0000, 0, 1);
        drive(1, 0, 4'hF, 8'h40, 16'h0000, 1, 0);
        expect_state(1, 3, 1, 0, 0, "R4 err without ack");

        // R5: pending write abandoned.
        do_reset(1'b0);
        idle();
        drive(1, 1, 4'hF, 8'h50, 16'hAAAA, 0, 0);
        drive(0, 1, 4'hF, 8'h50, 16'hAAAA, 0, 0);
        expect_state(1, 4, 0, 0, 0, "R5 cs dropped");

        // R6: sel changes during a pending read.
        do_reset(1'b0);
        idle();
        drive(1, 0, 4'h1, 8'h60, 16'h0000, 0, 0);
        drive(1, 0, 4'h2, 8'h60, 16'h0000, 1, 0);
        expect_state(1, 5, 1, 0, 0, "R6 sel moved on read");

        // R6: address moves on a pending write.
        do_reset(1'b0);
        idle();
        drive(1, 1, 4'hF, 8'h61, 16'h0101, 0, 0);
        drive(1, 1, 4'hF, 8'h62, 16'h0101, 1, 0);
        expect_state(1, 5, 0, 1, 0, "R6 adr moved on write");

        // R7 then R8: codes 2 and 4 together, then a later err rule.
        do_reset(1'b0);
        idle();
        drive(1, 1, 4'hF, 8'h70, 16'h7777, 0, 0);
        drive(0, 1, 4'hF, 8'h70, 16'h7777, 1, 0);
        expect_state(1, 2, 0, 0, 0, "R7 lowest code wins");
        drive(0, 0, 4'h0, 8'h00, 16'h0000, 0, 1);
        expect_state(1, 2, 0, 0, 0, "R8 sticky code");

        // R11: saturation of all three counters.
        do_reset(1'b0);
        idle();
        for (int i = 0; i < MAXC + 5; i++) drive(1, 0, 4'hF, 8'(i), 16'h0000, 1, 0);
        for (int i = 0; i < MAXC + 3; i++) drive(1, 1, 4'hF, 8'(i), 16'(i), 1, 1);
        expect_state(0, 0, MAXC, MAXC, MAXC, "R11 saturation");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule